// File: doc/BRIEF.md
# Dual-Drive PIO Cycle Strobe Generator

This block produces the read and write strobes for programmed-I/O transfers to two drives that share one cable. All timing is counted in bus clock cycles. A host-side sequencer raises a request together with a read/write flag and a drive select. The block then runs one transfer in three phases. First comes an address-setup wait whose length is common to both drives. Next the strobe is held active for the data-pulse count. Last comes a recovery wait, after which the block can take a new request.

Each drive has its own read timing byte and its own write timing byte. The data pulse sits in the upper nibble, biased by one. The recovery sits in the lower nibble, biased by two. A shared miscellaneous byte holds the address-setup count, biased by one, and the ready-sample delay, biased by two. The block picks the byte for the addressed drive and direction, and it latches the decoded counts when it accepts a request. A one-clock sample pulse marks the clock inside the strobe at which the drive-ready line would be sampled. The ready handshake itself is not part of this block. The strobes are active high at this boundary; pad logic inverts them for the cable.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, and at once whenever reset is asserted in the middle of a cycle, busy_o, done_o, rd_stb_o, wr_stb_o and rdy_tap_o are all low.
- R2: A request seen at a clock edge while idle starts a cycle, and busy_o is high from the next clock until, and including, the clock in which done_o is high.
- R3: The setup phase lasts misc_i[5:4]+1 clocks (1 to 4) for either drive, with both strobes low, and it is the first part of the busy period.
- R4: The active phase follows setup and lasts data+1 clocks, where data is bits 7:4 of the selected timing byte. rd_stb_o is high in this phase when rd_nwr_i=1 and wr_stb_o is high when rd_nwr_i=0. The two strobes are never high together.
- R5: The recovery phase follows the strobe and lasts rec+2 clocks, where rec is bits 3:0 of the selected timing byte, with both strobes low.
- R6: Drive d (drv_sel_i=d) uses rd_timing_i[8d+7:8d] for reads and wr_timing_i[8d+7:8d] for writes. The other three bytes have no effect.
- R7: done_o is high for exactly one clock, the last clock of recovery, and busy_o is low on the clock after it.
- R8: A request while busy is ignored: the running cycle keeps its length and no second cycle starts.
- R9: The timing bytes and the miscellaneous byte are captured when a request is accepted. Changing them during a cycle does not change that cycle.
- R10: rdy_tap_o pulses for one clock on active clock number misc_i[2:1]+2 (counting from 1). There is no pulse when that number is greater than the data-pulse length.
- R11: misc_i bits 7, 6, 3 and 0 (bit 6 being the read-prefetch enable) have no effect on any output.
- R12: The extreme encodings work: setup 1 and 4, data pulse 1 and 16, recovery 2 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request, taken only when idle |
| rd_nwr_i | input | 1 | 1 = read cycle, 0 = write cycle |
| drv_sel_i | input | 1 | Drive select (0 or 1) |
| rd_timing_i | input | 16 | Read timing bytes, drive d in bits 8d+7:8d |
| wr_timing_i | input | 16 | Write timing bytes, drive d in bits 8d+7:8d |
| misc_i | input | 8 | Shared setup [5:4], ready delay [2:1], other bits unused |
| rd_stb_o | output | 1 | Read strobe, active high |
| wr_stb_o | output | 1 | Write strobe, active high |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse on the last recovery clock |
| rdy_tap_o | output | 1 | Ready-sample point inside the strobe |

## Verification
The assertions assume that reset is released away from any request, and that the inputs settle between clock edges. They do not assume that req_i drops while busy: a request held across a whole cycle must still be ignored. The bench changes its inputs only on the falling edge, holds a request for one clock at a time except in the test that holds it on purpose, and uses in-range drive selects only. Every field value a timing byte can take is legal, so the stimulus covers both ends of every field without leaving the legal input space.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

  localparam int CNT_W = 5;   // wide enough for 17 recovery clocks

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // data pulse: stored as clocks-1 in a nibble
  function automatic logic [CNT_W-1:0] pulse_clocks(input logic [3:0] f);
    return {1'b0, f} + CNT_W'(1);
  endfunction

  // recovery: stored as clocks-2 in a nibble
  function automatic logic [CNT_W-1:0] recov_clocks(input logic [3:0] f);
    return {1'b0, f} + CNT_W'(2);
  endfunction

  // shared address setup: stored as clocks-1 in two bits
  function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] f);
    return {3'b000, f} + CNT_W'(1);
  endfunction

  // ready-sample delay: stored as clocks-2 in two bits
  function automatic logic [CNT_W-1:0] tap_clocks(input logic [1:0] f);
    return {3'b000, f} + CNT_W'(2);
  endfunction

endpackage

// File: rtl/pio_bank_sel.sv
module pio_bank_sel #(
  parameter int N_DRV = 2,
  parameter int REG_W = 8,
  localparam int SEL_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
  input  logic [SEL_W-1:0]       drv_sel,
  input  logic                   rd_nwr,
  input  logic [N_DRV*REG_W-1:0] rd_bank,
  input  logic [N_DRV*REG_W-1:0] wr_bank,
  output logic [REG_W-1:0]       cyc_reg
);

  logic [REG_W-1:0] rd_arr [N_DRV];
  logic [REG_W-1:0] wr_arr [N_DRV];

  for (genvar g = 0; g < N_DRV; g++) begin : g_unpack
    assign rd_arr[g] = rd_bank[g*REG_W +: REG_W];
    assign wr_arr[g] = wr_bank[g*REG_W +: REG_W];
  end

  always_comb begin
    cyc_reg = rd_nwr ? rd_arr[drv_sel] : wr_arr[drv_sel];
  end

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             rd_nwr,
  input  logic [CNT_W-1:0] setup_clk,
  input  logic [CNT_W-1:0] pulse_clk,
  input  logic [CNT_W-1:0] recov_clk,
  input  logic [CNT_W-1:0] tap_clk,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             busy,
  output logic             done,
  output logic             rdy_tap
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_rd_q;
  logic [CNT_W-1:0] pulse_q, recov_q, tap_q;

  // named internal events
  logic             accept;
  logic             last;
  logic [CNT_W-1:0] elapsed;
  logic             stb_any;

  assign accept  = (phase_q == PH_IDLE) && req;
  assign last    = (cnt_q == '0);
  assign elapsed = pulse_q - cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      pulse_q <= CNT_W'(1);
      recov_q <= CNT_W'(2);
      tap_q   <= CNT_W'(2);
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_SETUP;
          cnt_q   <= setup_clk - CNT_W'(1);
          is_rd_q <= rd_nwr;
          pulse_q <= pulse_clk;
          recov_q <= recov_clk;
          tap_q   <= tap_clk;
        end
        PH_SETUP: if (last) begin
          phase_q <= PH_ACTIVE;
          cnt_q   <= pulse_q - CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        PH_ACTIVE: if (last) begin
          phase_q <= PH_RECOV;
          cnt_q   <= recov_q - CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        PH_RECOV: if (last) begin
          phase_q <= PH_IDLE;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy    = (phase_q != PH_IDLE);
  assign rd_stb  = (phase_q == PH_ACTIVE) && is_rd_q;
  assign wr_stb  = (phase_q == PH_ACTIVE) && !is_rd_q;
  assign done    = (phase_q == PH_RECOV) && last;
  assign rdy_tap = (phase_q == PH_ACTIVE) && (elapsed == tap_q);
  assign stb_any = rd_stb || wr_stb;

  // checker state: length of the current strobe run
  logic [CNT_W-1:0] stb_len_q;
  logic             stb_prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_len_q  <= '0;
      stb_prev_q <= 1'b0;
    end else begin
      stb_prev_q <= stb_any;
      stb_len_q  <= stb_any ? stb_len_q + CNT_W'(1) : '0;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> busy);

  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  assert_strobe_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_prev_q && !stb_any) |-> (stb_len_q == pulse_q));

  assert_tap_in_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_tap |-> stb_any);

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int N_DRV = 2,
  parameter int REG_W = 8,
  localparam int SEL_W = (N_DRV > 1) ? $clog2(N_DRV) : 1,
  localparam int HALF  = REG_W / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic                   rd_nwr_i,
  input  logic [SEL_W-1:0]       drv_sel_i,
  input  logic [N_DRV*REG_W-1:0] rd_timing_i,
  input  logic [N_DRV*REG_W-1:0] wr_timing_i,
  input  logic [7:0]             misc_i,
  output logic                   rd_stb_o,
  output logic                   wr_stb_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   rdy_tap_o
);

  logic [REG_W-1:0] cyc_sel;
  logic [CNT_W-1:0] setup_clk, pulse_clk, recov_clk, tap_clk;
  logic             unused_misc;

  pio_bank_sel #(.N_DRV(N_DRV), .REG_W(REG_W)) u_sel (
    .drv_sel (drv_sel_i),
    .rd_nwr  (rd_nwr_i),
    .rd_bank (rd_timing_i),
    .wr_bank (wr_timing_i),
    .cyc_reg (cyc_sel)
  );

  assign pulse_clk   = pulse_clocks(cyc_sel[REG_W-1 -: 4]);
  assign recov_clk   = recov_clocks(cyc_sel[3:0]);
  assign setup_clk   = setup_clocks(misc_i[5:4]);
  assign tap_clk     = tap_clocks(misc_i[2:1]);
  // prefetch enable (bit 6) and spare bits do not alter strobe timing
  assign unused_misc = ^{misc_i[7:6], misc_i[3], misc_i[0], cyc_sel[HALF-1:4]};

  pio_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_i),
    .rd_nwr    (rd_nwr_i),
    .setup_clk (setup_clk),
    .pulse_clk (pulse_clk),
    .recov_clk (recov_clk),
    .tap_clk   (tap_clk),
    .rd_stb    (rd_stb_o),
    .wr_stb    (wr_stb_o),
    .busy      (busy_o),
    .done      (done_o),
    .rdy_tap   (rdy_tap_o)
  );

endmodule

// File: tb/tb_pio_strobe_gen.sv
`timescale 1ns/1ps
module tb_pio_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, rd_nwr = 1'b0;
  logic [0:0]  drv = 1'b0;
  logic [15:0] rdt = '0, wrt = '0;
  logic [7:0]  misc = '0;
  logic        rd_stb, wr_stb, busy, done, tap;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pio_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rd_nwr_i(rd_nwr),
    .drv_sel_i(drv), .rd_timing_i(rdt), .wr_timing_i(wrt), .misc_i(misc),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .busy_o(busy), .done_o(done),
    .rdy_tap_o(tap)
  );

  // {drv, rd, cyc, misc, exp_setup[3], exp_data[5], exp_rec[5], exp_tap[3]} (tap 0 = none)
  localparam logic [33:0] VECS [0:7] = '{
    {1'b0, 1'b1, 8'h31, 8'h00, 3'd1, 5'd4,  5'd3,  3'd2},
    {1'b0, 1'b0, 8'h52, 8'h10, 3'd2, 5'd6,  5'd4,  3'd2},
    {1'b1, 1'b1, 8'hF0, 8'h30, 3'd4, 5'd16, 5'd2,  3'd2},
    {1'b1, 1'b0, 8'h0F, 8'h06, 3'd1, 5'd1,  5'd17, 3'd0},
    {1'b0, 1'b1, 8'h24, 8'h62, 3'd3, 5'd3,  5'd6,  3'd3},
    {1'b1, 1'b1, 8'h13, 8'hC9, 3'd1, 5'd2,  5'd5,  3'd2},
    {1'b1, 1'b0, 8'h77, 8'h24, 3'd3, 5'd8,  5'd9,  3'd4},
    {1'b0, 1'b0, 8'h00, 8'h00, 3'd1, 5'd1,  5'd2,  3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic d, input logic rd, input logic [7:0] cyc, input logic [7:0] m);
    rdt = '0; wrt = '0;  // decoy bytes in the unused banks
    if (rd) rdt[d*8 +: 8] = cyc; else wrt[d*8 +: 8] = cyc;
    drv = d; rd_nwr = rd; misc = m;
  endtask

  // launch one cycle and measure its phases at falling edges
  task automatic run(input logic rd, input bit hold, input bit change,
                     output int s_n, output int d_n, output int r_n,
                     output int tap_pos, output int done_n,
                     output int done_last, output int bad);
    s_n = 0; d_n = 0; r_n = 0; tap_pos = 0; done_n = 0; done_last = 0; bad = 0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); if (!hold) req = 1'b0;
    if (change) begin rdt = 16'hFFFF; wrt = 16'hFFFF; misc = 8'h36; end
    for (int k = 0; k < 64; k++) begin
      if (k > 0) @(negedge clk);
      if (!busy) break;
      if (rd ? wr_stb : rd_stb) bad++;
      if (rd ? rd_stb : wr_stb) begin
        if (r_n > 0) bad++;
        d_n++;
        if (tap) begin if (tap_pos != 0) bad++; tap_pos = d_n; end
      end else begin
        if (tap) bad++;
        if (d_n == 0) s_n++; else r_n++;
      end
      done_last = done ? 1 : 0;
      if (done) begin done_n++; req = 1'b0; end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s, d, r, tp, dn, dl, bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy after reset", busy, 0);
    chk("R1 strobes after reset", rd_stb | wr_stb | done | tap, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      logic [33:0] v;
      v = VECS[i];
      load(v[33], v[32], v[31:24], v[23:16]);
      run(v[32], 1'b0, 1'b0, s, d, r, tp, dn, dl, bad);
      chk($sformatf("R3 R12 setup length vec%0d", i), s, int'(v[15:13]));
      chk($sformatf("R4 R6 R12 pulse length vec%0d", i), d, int'(v[12:8]));
      chk($sformatf("R5 R6 R12 recovery length vec%0d", i), r, int'(v[7:3]));
      chk($sformatf("R10 R11 tap position vec%0d", i), tp, int'(v[2:0]));
      chk($sformatf("R7 done count vec%0d", i), dn, 1);
      chk($sformatf("R7 done on last clock vec%0d", i), dl, 1);
      chk($sformatf("R4 strobe kind vec%0d", i), bad, 0);
      chk($sformatf("R2 R7 idle after done vec%0d", i), busy, 0);
    end

    // R8: request held high through the whole cycle
    load(1'b1, 1'b0, 8'h32, 8'h10);
    run(1'b0, 1'b1, 1'b0, s, d, r, tp, dn, dl, bad);
    chk("R8 setup with held request", s, 2);
    chk("R8 pulse with held request", d, 4);
    chk("R8 recovery with held request", r, 4);
    chk("R8 single done", dn, 1);
    @(negedge clk);
    chk("R8 no restart", busy, 0);

    // R9: timing changed right after acceptance
    load(1'b0, 1'b1, 8'h21, 8'h00);
    run(1'b1, 1'b0, 1'b1, s, d, r, tp, dn, dl, bad);
    chk("R9 setup captured", s, 1);
    chk("R9 pulse captured", d, 3);
    chk("R9 recovery captured", r, 3);
    chk("R9 tap captured", tp, 2);

    // R1: reset in the middle of the strobe
    load(1'b0, 1'b1, 8'hF5, 8'h00);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 strobe high before reset", rd_stb, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 busy cleared by reset", busy, 0);
    chk("R1 strobe cleared by reset", rd_stb | wr_stb | done, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 stays idle without request", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule